// File: doc/BRIEF.md
# Vector load address generator

This block expands one vectorised load into an ordered stream of per-element memory requests. Each request carries a 64-bit effective address, the destination register number that will receive the element, and the element index. The operation is captured from a one-cycle start pulse. The pulse carries an addressing form (immediate offset or register-plus-register index), per-operand vector/scalar flags, an element-stride select, an element size, an immediate and a vector length.

The block has two combinational register-file read ports, one for the base operand and one for the index operand. It drives the register number it needs on each port, and the register file returns that register's contents in the same cycle. A vector operand steps its register number by one per element. A scalar operand keeps the register number it was given. These flags decide the kind of address stream: a gather over a vector of base registers, a contiguous unit-stride block, an immediate-scaled element stride, a single scalar access, or an indexed splat. Requests leave under a valid/ready handshake. A one-cycle done pulse marks the end of the operation.

Top module: `vld_agen`

## Requirements
- R1: In immediate form (mode_i=0) with a vector base (base_vec_i=1), element i is addressed at GPR[base+i]+imm and is written to register dst+i when dst_vec_i=1; no stride is applied.
- R2: In immediate form with a vector base and a scalar destination (dst_vec_i=0), there are vl requests at GPR[base+i]+imm, and every one of them targets register dst.
- R3: In immediate form with a scalar base, a vector destination and stride_el_i=0, element i is addressed at GPR[base]+imm+i*2^esize_i and goes to register dst+i, where esize_i codes 1, 2, 4 or 8 bytes as 0 to 3.
- R4: In immediate form with a scalar base, a vector destination and stride_el_i=1, element i is addressed at GPR[base]+imm*i and goes to register dst+i.
- R5: When every operand in use is scalar and vl is nonzero, exactly one request is issued, at GPR[base]+imm for the immediate form, with element index 0 and register dst.
- R6: In indexed form (mode_i=1) with a vector base and a scalar index (idx_vec_i=0), element i is addressed at GPR[base+i]+GPR[idx].
- R7: In indexed form with a scalar base, a scalar index and a vector destination, every element uses the address GPR[base]+GPR[idx], and element i goes to register dst+i.
- R8: Requests leave in ascending element order starting at 0. While req_ready_i is low, the pending request's valid, address, register and index stay unchanged.
- R9: A start with vl_i=0 issues no request, and done_o is high in the cycle after the start.
- R10: done_o is high for exactly one cycle, namely the cycle after the last request is accepted, and it is never high together with req_valid_o.
- R11: Register numbers wrap modulo 128, and address arithmetic wraps modulo 2^64.
- R12: A start pulse that arrives while busy_o is high is ignored, and the operation in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; the operation fields are captured when idle |
| mode_i | input | 1 | 0 selects immediate form, 1 selects indexed form |
| stride_el_i | input | 1 | Immediate form, scalar base, vector destination: 1 selects element stride, 0 selects unit stride |
| dst_vec_i | input | 1 | Destination is a vector |
| base_vec_i | input | 1 | Base operand is a vector |
| idx_vec_i | input | 1 | Index operand is a vector (indexed form only) |
| esize_i | input | 2 | log2 of the element size in bytes |
| imm_i | input | 64 | Immediate offset, sign-extended |
| vl_i | input | 8 | Vector length |
| dst_i | input | 7 | Destination register number |
| base_i | input | 7 | Base register number |
| idx_i | input | 7 | Index register number |
| busy_o | output | 1 | An operation is in progress |
| base_addr_o | output | 7 | Register number read on the base port |
| base_data_i | input | 64 | Contents of the base port register |
| idx_addr_o | output | 7 | Register number read on the index port |
| idx_data_i | input | 64 | Contents of the index port register |
| req_valid_o | output | 1 | A request is offered |
| req_ready_i | input | 1 | The consumer accepts the request |
| req_addr_o | output | 64 | Effective address |
| req_rd_o | output | 7 | Destination register number |
| req_elem_o | output | 8 | Element index |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two events can fall in the same cycle. The first is the acceptance of the final request, which ends the run. The second is a new start pulse, or a run of stalls just before the end. The bench holds ready low at irregular points on several table rows, including the cycle before the last element. It checks that the next offered element is always the expected one, and that done_o appears exactly one cycle after the last acceptance and never next to a valid request. It also sends a second start with different fields while a run is stalled, and then checks that every remaining request still matches the first operation.

// File: rtl/vld_agen_pkg.sv
package vld_agen_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned NREG  = 128;
  localparam int unsigned REG_W = $clog2(NREG);
  localparam int unsigned VL_W  = 8;

  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_IDX = 1'b1
  } agen_mode_e;
endpackage

// File: rtl/vld_agen_seq.sv
// Element sequencer: busy, element counter, done pulse.
module vld_agen_seq #(
  parameter int unsigned VL_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            single_i,
  input  logic            ready_i,
  output logic            busy_o,
  output logic            accept_o,
  output logic [VL_W-1:0] elem_o,
  output logic            done_o
);
  logic [VL_W-1:0] last_q;

  assign accept_o = busy_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      elem_o <= '0;
      last_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          if (vl_i == '0) begin
            done_o <= 1'b1;
          end else begin
            busy_o <= 1'b1;
            elem_o <= '0;
            last_q <= single_i ? '0 : vl_i - 1'b1;
          end
        end
      end else if (ready_i) begin
        if (elem_o == last_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          elem_o <= elem_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vld_agen_regnum.sv
// Register numbering for destination, base and index operands.
module vld_agen_regnum #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned VL_W  = 8,
  parameter int unsigned NOPS  = 3
) (
  input  logic [NOPS-1:0][REG_W-1:0] reg_i,
  input  logic [NOPS-1:0]            vec_i,
  input  logic [VL_W-1:0]            elem_i,
  output logic [NOPS-1:0][REG_W-1:0] reg_o
);
  logic [REG_W-1:0] step;
  assign step = REG_W'(elem_i);

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    // wraps modulo 2^REG_W
    assign reg_o[g] = vec_i[g] ? reg_i[g] + step : reg_i[g];
  end
endmodule

// File: rtl/vld_agen_addr.sv
// Effective address: gather, unit stride, element stride, indexed.
module vld_agen_addr
  import vld_agen_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  agen_mode_e mode_i,
  input  logic       stride_el_i,
  input  logic       dst_vec_i,
  input  logic       base_vec_i,
  input  logic [1:0] esize_i,
  input  logic [AW-1:0] imm_i,
  input  logic [AW-1:0] base_data_i,
  input  logic [AW-1:0] idx_data_i,
  output logic [AW-1:0] addr_o
);
  logic          el_mode;
  logic [AW-1:0] step_amt;
  logic [AW-1:0] acc_q;

  assign el_mode  = stride_el_i & dst_vec_i & ~base_vec_i;
  assign step_amt = el_mode ? imm_i : (AW'(1) << esize_i);

  // running offset replaces an i*imm multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= '0;
    else if (step_i) acc_q <= acc_q + step_amt;
  end

  always_comb begin
    if (mode_i == MODE_IDX)  addr_o = base_data_i + idx_data_i;
    else if (base_vec_i)     addr_o = base_data_i + imm_i;
    else if (el_mode)        addr_o = base_data_i + acc_q;
    else                     addr_o = base_data_i + imm_i + acc_q;
  end
endmodule

// File: rtl/vld_agen.sv
module vld_agen
  import vld_agen_pkg::*;
#(
  parameter int unsigned AW   = XLEN,
  parameter int unsigned RW   = REG_W,
  parameter int unsigned VLW  = VL_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic           stride_el_i,
  input  logic           dst_vec_i,
  input  logic           base_vec_i,
  input  logic           idx_vec_i,
  input  logic [1:0]     esize_i,
  input  logic [AW-1:0]  imm_i,
  input  logic [VLW-1:0] vl_i,
  input  logic [RW-1:0]  dst_i,
  input  logic [RW-1:0]  base_i,
  input  logic [RW-1:0]  idx_i,
  output logic           busy_o,
  output logic [RW-1:0]  base_addr_o,
  input  logic [AW-1:0]  base_data_i,
  output logic [RW-1:0]  idx_addr_o,
  input  logic [AW-1:0]  idx_data_i,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [AW-1:0]  req_addr_o,
  output logic [RW-1:0]  req_rd_o,
  output logic [VLW-1:0] req_elem_o,
  output logic           done_o
);
  localparam int unsigned NOPS = 3;

  agen_mode_e    mode_q;
  logic          el_q, dv_q, bv_q, iv_q;
  logic [1:0]    esz_q;
  logic [AW-1:0] imm_q;
  logic [RW-1:0] dst_q, base_q, idx_q;
  logic          load, accept, single;
  logic [NOPS-1:0][RW-1:0] regs_in, regs_out;
  logic [NOPS-1:0]         vecs;

  assign load   = start_i & ~busy_o;
  // one request when every operand in use is scalar
  assign single = ~(dst_vec_i | base_vec_i | (mode_i & idx_vec_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IMM;
      el_q   <= 1'b0;
      dv_q   <= 1'b0;
      bv_q   <= 1'b0;
      iv_q   <= 1'b0;
      esz_q  <= '0;
      imm_q  <= '0;
      dst_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      mode_q <= agen_mode_e'(mode_i);
      el_q   <= stride_el_i;
      dv_q   <= dst_vec_i;
      bv_q   <= base_vec_i;
      iv_q   <= idx_vec_i & mode_i;
      esz_q  <= esize_i;
      imm_q  <= imm_i;
      dst_q  <= dst_i;
      base_q <= base_i;
      idx_q  <= idx_i;
    end
  end

  vld_agen_seq #(.VL_W(VLW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .single_i (single),
    .ready_i  (req_ready_i),
    .busy_o   (busy_o),
    .accept_o (accept),
    .elem_o   (req_elem_o),
    .done_o   (done_o)
  );

  assign regs_in = {idx_q, base_q, dst_q};
  assign vecs    = {iv_q, bv_q, dv_q};

  vld_agen_regnum #(.REG_W(RW), .VL_W(VLW), .NOPS(NOPS)) u_regnum (
    .reg_i  (regs_in),
    .vec_i  (vecs),
    .elem_i (req_elem_o),
    .reg_o  (regs_out)
  );

  assign req_rd_o    = regs_out[0];
  assign base_addr_o = regs_out[1];
  assign idx_addr_o  = regs_out[2];

  vld_agen_addr #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (accept),
    .mode_i      (mode_q),
    .stride_el_i (el_q),
    .dst_vec_i   (dv_q),
    .base_vec_i  (bv_q),
    .esize_i     (esz_q),
    .imm_i       (imm_q),
    .base_data_i (base_data_i),
    .idx_data_i  (idx_data_i),
    .addr_o      (req_addr_o)
  );

  assign req_valid_o = busy_o;
endmodule

// File: rtl/vld_agen_chk.sv
module vld_agen_chk #(
  parameter int unsigned AW  = 64,
  parameter int unsigned RW  = 7,
  parameter int unsigned VLW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [VLW-1:0] vl_i,
  input logic           busy_o,
  input logic           req_valid_o,
  input logic           req_ready_i,
  input logic [AW-1:0]  req_addr_o,
  input logic [RW-1:0]  req_rd_o,
  input logic [VLW-1:0] req_elem_o,
  input logic           done_o
);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_rd_o) && $stable(req_elem_o));

  a_r8_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=>
      (req_valid_o ? (req_elem_o == $past(req_elem_o) + 1'b1) : done_o));

  a_r8_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> req_elem_o == '0);

  a_r9_zero_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && vl_i == '0 |=> done_o && !req_valid_o);

  a_r10_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_valid_o);
endmodule

bind vld_agen vld_agen_chk #(.AW(AW), .RW(RW), .VLW(VLW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .vl_i        (vl_i),
  .busy_o      (busy_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_rd_o    (req_rd_o),
  .req_elem_o  (req_elem_o),
  .done_o      (done_o)
);

// File: tb/vld_agen_bench.sv
module vld_agen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0, stride_el_i = 1'b0, dst_vec_i = 1'b0;
  logic        base_vec_i = 1'b0, idx_vec_i = 1'b0;
  logic [1:0]  esize_i = '0;
  logic [63:0] imm_i = '0;
  logic [7:0]  vl_i = '0;
  logic [6:0]  dst_i = '0, base_i = '0, idx_i = '0;
  logic        busy_o;
  logic [6:0]  base_addr_o, idx_addr_o;
  logic [63:0] base_data_i, idx_data_i;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [63:0] req_addr_o;
  logic [6:0]  req_rd_o;
  logic [7:0]  req_elem_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5ns clk_i = ~clk_i;

  function automatic logic [63:0] gpr(input logic [6:0] n);
    return 64'h0100_0000_0000_0000 * 64'(n) + 64'h10 * 64'(n) + 64'h3;
  endfunction

  assign base_data_i = gpr(base_addr_o);
  assign idx_data_i  = gpr(idx_addr_o);

  vld_agen u_vld_agen (.*);

  typedef struct packed {
    logic        mode, el, dv, bv, iv;
    logic [1:0]  esz;
    logic [63:0] imm;
    logic [7:0]  vl;
    logic [6:0]  dst, base, idx;
    logic        stall;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,64'h40,8'd4,7'd10,7'd20,7'd0,1'b0,4'd1},          // R1
    '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,-64'sd8,8'd3,7'd5,7'd30,7'd0,1'b1,4'd2},          // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd3,64'h100,8'd5,7'd40,7'd2,7'd0,1'b1,4'd3},          // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'd1,64'h8,8'd3,7'd60,7'd4,7'd0,1'b0,4'd3},            // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd2,64'h30,8'd4,7'd70,7'd6,7'd0,1'b1,4'd4},           // R4
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd2,64'h18,8'd6,7'd80,7'd7,7'd0,1'b0,4'd5},           // R5
    '{1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,64'h0,8'd4,7'd90,7'd50,7'd9,1'b1,4'd6},           // R6
    '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,64'h0,8'd4,7'd126,7'd11,7'd12,1'b0,4'd7},         // R7, R11 dst wrap
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,64'hFFFF_FFFF_FFFF_FF00,8'd4,7'd127,7'd126,7'd0,1'b1,4'd11}, // R11
    '{1'b1,1'b0,1'b1,1'b1,1'b1,2'd0,64'h0,8'd3,7'd1,7'd100,7'd110,1'b0,4'd6}           // R6 vector index
  };

  function automatic int exp_count(input row_t r);
    if (r.vl == 0) return 0;
    if (r.dv || r.bv || (r.mode && r.iv)) return int'(r.vl);
    return 1;
  endfunction

  function automatic logic [63:0] exp_addr(input row_t r, input int i);
    logic [6:0] b, x;
    b = r.base + (r.bv ? 7'(i) : 7'd0);
    x = r.idx + ((r.mode && r.iv) ? 7'(i) : 7'd0);
    if (r.mode)            return gpr(b) + gpr(x);
    if (r.bv)              return gpr(b) + r.imm;
    if (r.dv && r.el)      return gpr(r.base) + r.imm * 64'(i);
    if (r.dv)              return gpr(r.base) + r.imm + 64'(i) * (64'd1 << r.esz);
    return gpr(r.base) + r.imm;
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input row_t r);
    start_i = 1'b1; mode_i = r.mode; stride_el_i = r.el; dst_vec_i = r.dv;
    base_vec_i = r.bv; idx_vec_i = r.iv; esize_i = r.esz; imm_i = r.imm;
    vl_i = r.vl; dst_i = r.dst; base_i = r.base; idx_i = r.idx;
  endtask

  // drives at negedge; samples at negedge; optional foreign start while busy
  task automatic run(input row_t r, input bit intrude);
    int e, n, cyc;
    bit seen_done;
    n = exp_count(r); e = 0; cyc = 0; seen_done = 1'b0;
    @(negedge clk_i);
    apply(r);
    req_ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!seen_done && cyc < 1000) begin
      if (intrude && cyc == 1) begin
        apply('{1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,64'h5555,8'd2,7'd3,7'd3,7'd0,1'b0,4'd12});
      end else start_i = 1'b0;
      if (done_o) begin
        seen_done = 1'b1;
        chk(e == n, int'(r.req), "done after all elements", 64'(e), 64'(n));
        chk(!req_valid_o, 10, "done with valid", 64'(req_valid_o), 64'd0);
      end else if (req_valid_o) begin
        req_ready_i = r.stall ? ((cyc % 3) != 1) : 1'b1;
        if (e == n - 1 && r.stall && cyc < 4) req_ready_i = 1'b0;
        if (req_ready_i) begin
          logic [6:0] erd;
          erd = r.dst + (r.dv ? 7'(e) : 7'd0);
          chk(req_elem_o == 8'(e), 8, "element index", 64'(req_elem_o), 64'(e));
          chk(req_addr_o == exp_addr(r, e), int'(r.req), "address",
              req_addr_o, exp_addr(r, e));
          chk(req_rd_o == erd, int'(r.req), "dest register", 64'(req_rd_o), 64'(erd));
          e++;
        end
      end
      cyc++;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    if (!seen_done) chk(1'b0, int'(r.req), "timeout waiting for done", 64'(cyc), 64'd0);
    // R10: one-cycle pulse, idle afterwards
    req_ready_i = 1'b0;
    chk(!done_o && !req_valid_o, 10, "idle after done",
        {62'd0, done_o, req_valid_o}, 64'd0);
  endtask

  initial begin
    #1_000_000ns;
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!req_valid_o && !done_o && !busy_o, 8, "reset state",
        {61'd0, req_valid_o, done_o, busy_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < NROWS; k++) run(ROWS[k], 1'b0);

    // R12: second start during a stalled run is ignored
    run(ROWS[2], 1'b1);

    // R9: zero vector length
    @(negedge clk_i);
    apply('{1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,64'h0,8'd0,7'd1,7'd1,7'd0,1'b0,4'd9});
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, 9, "done after zero-length start", 64'(done_o), 64'd1);
    chk(!req_valid_o, 9, "no request for zero length", 64'(req_valid_o), 64'd0);
    @(negedge clk_i);
    chk(!done_o && !req_valid_o, 10, "zero-length done is one cycle",
        {62'd0, done_o, req_valid_o}, 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule